// File: doc/BRIEF.md
# Selectable Pin Interrupt Unit

This block turns GPIO pin activity into per-channel interrupt requests. It watches a parameterised number of channels (eight by default). Each channel is steered to any one pin of three GPIO ports by a small select register holding a linear pin code. A channel works in one of two ways. In edge mode it flags rising transitions, falling transitions or both. In level mode it reports a pin that sits at a programmable active level. The level can be flipped by software, so a handler can wait for the opposite level.

Software reaches the unit through a simple synchronous word-addressed register bus. The bus writes on the clock edge when the select and write strobes are both high. Read data is combinational from the address. Each rising and falling arm-enable vector has a plain write address, a set alias and a clear alias. Pending status and the two edge-history vectors are cleared by writing ones. Every channel drives its own interrupt output, which mirrors its pending bit.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every register reads zero and all interrupt outputs are low.
- R2: Channel c's select register lives at word 16+c and holds a 6-bit code. Codes 0..23 pick port 0 pins 0..23, codes 24..55 pick port 1 pins 0..31, and codes 56..63 pick port 2 pins 0..7.
- R3: The word offsets are as follows. Offsets 1 and 4 write the rise-arm and fall-arm vectors directly. Offsets 2 and 5 set the bits written as 1, and offsets 3 and 6 clear them. Bits written as 0 through offsets 2, 3, 5 and 6 leave the vector unchanged.
- R4: A pin change reaches the interrupt output on the third rising clock edge after it is applied, and not earlier.
- R5: In edge mode (bit c of the mode word at offset 0 is 0), a rising edge sets pending bit c if rise-arm bit c is 1. A falling edge sets it if fall-arm bit c is 1. With both arms set, both directions set it.
- R6: In edge mode an edge in a direction that is not armed leaves pending status unchanged.
- R7: The edge history words record every detected edge of each channel, whatever the mode and arms. Offset 7 records rising edges and offset 8 records falling edges. A bit stays set until a 1 is written to it.
- R8: In edge mode, writing 1 to bit c of the pending word (offset 9) clears it. Writing 0 has no effect.
- R9: In level mode (mode bit 1), pending bit c is 1 only while rise-arm bit c is 1 and the synchronised pin equals fall-arm bit c. Fall-arm 1 means active high and 0 means active low. Pending drops when the level goes away or the channel is disarmed.
- R10: In level mode, writing 1 to pending bit c inverts fall-arm bit c.
- R11: Interrupt output c equals pending bit c as read at offset 9.
- R12: The alias offsets 2, 3, 5 and 6 and all unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | Write qualifier for the access |
| busAddr | input | 5 | Word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| port0Pins | input | 24 | Port 0 pin levels |
| port1Pins | input | 32 | Port 1 pin levels |
| port2Pins | input | 8 | Port 2 pins 0..7 levels |
| irqOut | output | 8 | One interrupt request per channel |

## Verification
A select register that holds the wrong code would steer a channel to the wrong pin. That channel would stay silent when the intended pin moves, and this shows on its output three cycles after the stimulus. A corrupted arm, mode or pending bit would show either as a request that appears when it should not, or as one that does not drop after a clear. The clear case is visible one cycle after the write. The edge history words and the fall-arm readback after a level-mode status write also expose the internal state directly through the bus.

// File: rtl/pin_irq_pkg.sv
`timescale 1ns/1ps
package pin_irq_pkg;
  // Word offsets; software decodes this order.
  localparam int OFS_MODE  = 0;
  localparam int OFS_RENA  = 1;
  localparam int OFS_RSET  = 2;
  localparam int OFS_RCLR  = 3;
  localparam int OFS_FENA  = 4;
  localparam int OFS_FSET  = 5;
  localparam int OFS_FCLR  = 6;
  localparam int OFS_REDGE = 7;
  localparam int OFS_FEDGE = 8;
  localparam int OFS_PEND  = 9;
  localparam int OFS_SEL   = 16;

  typedef struct packed {
    logic modeWr;
    logic renaWr;
    logic renaSet;
    logic renaClr;
    logic fenaWr;
    logic fenaSet;
    logic fenaClr;
    logic redgeClr;
    logic fedgeClr;
    logic pendClr;
  } pinIrqStb_t;
endpackage

// File: rtl/pin_irq_chan.sv
`timescale 1ns/1ps
module pin_irq_chan #(
  parameter int PIN_N  = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PIN_N-1:0]  allPins,
  input  logic [CODE_W-1:0] code,
  output logic              lvl,
  output logic              riseHit,
  output logic              fallHit
);
  logic picked;
  logic syncA, syncB, prevQ;

  generate
    if (PIN_N == (1 << CODE_W)) begin : g_full
      assign picked = allPins[code];
    end else begin : g_partial
      assign picked = (int'(code) < PIN_N) ? allPins[code] : 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      syncA <= picked;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign lvl     = syncB;
  assign riseHit = syncB & ~prevQ;
  assign fallHit = ~syncB & prevQ;
endmodule

// File: rtl/pin_irq_ctrl.sv
`timescale 1ns/1ps
module pin_irq_ctrl import pin_irq_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 6,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                     busSel,
  input  logic                     busWr,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [NUM_CH-1:0]        modeQ,
  input  logic [NUM_CH-1:0]        renaQ,
  input  logic [NUM_CH-1:0]        fenaQ,
  input  logic [NUM_CH-1:0]        redgeQ,
  input  logic [NUM_CH-1:0]        fedgeQ,
  input  logic [NUM_CH-1:0]        pendQ,
  input  logic [NUM_CH*CODE_W-1:0] selFlat,
  output pinIrqStb_t               stb,
  output logic [NUM_CH-1:0]        selWr,
  output logic [DATA_W-1:0]        busRdata
);
  logic wrEn;
  int   addrI;

  assign wrEn  = busSel & busWr;
  assign addrI = int'(busAddr);

  assign stb.modeWr   = wrEn && (addrI == OFS_MODE);
  assign stb.renaWr   = wrEn && (addrI == OFS_RENA);
  assign stb.renaSet  = wrEn && (addrI == OFS_RSET);
  assign stb.renaClr  = wrEn && (addrI == OFS_RCLR);
  assign stb.fenaWr   = wrEn && (addrI == OFS_FENA);
  assign stb.fenaSet  = wrEn && (addrI == OFS_FSET);
  assign stb.fenaClr  = wrEn && (addrI == OFS_FCLR);
  assign stb.redgeClr = wrEn && (addrI == OFS_REDGE);
  assign stb.fedgeClr = wrEn && (addrI == OFS_FEDGE);
  assign stb.pendClr  = wrEn && (addrI == OFS_PEND);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_selWr
      assign selWr[i] = wrEn && (addrI == OFS_SEL + i);
    end
  endgenerate

  always_comb begin
    busRdata = '0;
    case (addrI)
      OFS_MODE:  busRdata[NUM_CH-1:0] = modeQ;
      OFS_RENA:  busRdata[NUM_CH-1:0] = renaQ;
      OFS_FENA:  busRdata[NUM_CH-1:0] = fenaQ;
      OFS_REDGE: busRdata[NUM_CH-1:0] = redgeQ;
      OFS_FEDGE: busRdata[NUM_CH-1:0] = fedgeQ;
      OFS_PEND:  busRdata[NUM_CH-1:0] = pendQ;
      default:   busRdata = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (addrI == OFS_SEL + i) busRdata[CODE_W-1:0] = selFlat[i*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/pin_irq_dpath.sv
`timescale 1ns/1ps
module pin_irq_dpath import pin_irq_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int PIN_N  = 64,
  parameter int CODE_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pinIrqStb_t               stb,
  input  logic [NUM_CH-1:0]        selWr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [PIN_N-1:0]         allPins,
  output logic [NUM_CH-1:0]        modeQ,
  output logic [NUM_CH-1:0]        renaQ,
  output logic [NUM_CH-1:0]        fenaQ,
  output logic [NUM_CH-1:0]        redgeQ,
  output logic [NUM_CH-1:0]        fedgeQ,
  output logic [NUM_CH-1:0]        pendQ,
  output logic [NUM_CH*CODE_W-1:0] selFlat
);
  logic [NUM_CH-1:0]             wd;
  logic [CODE_W-1:0]             selData;
  logic                          unusedData;
  logic [NUM_CH-1:0][CODE_W-1:0] selQ;
  logic [NUM_CH-1:0]             lvl, rise, fall;
  logic [NUM_CH-1:0]             renaNext, fenaNext, fenaBase, pendNext;
  logic [NUM_CH-1:0]             redgeNext, fedgeNext, pendMask;

  assign wd         = wrData[NUM_CH-1:0];
  assign selData    = wrData[CODE_W-1:0];
  assign unusedData = ^wrData;
  assign selFlat    = selQ;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      pin_irq_chan #(.PIN_N(PIN_N), .CODE_W(CODE_W)) u_chan (
        .clk     (clk),
        .rstN    (rstN),
        .allPins (allPins),
        .code    (selQ[i]),
        .lvl     (lvl[i]),
        .riseHit (rise[i]),
        .fallHit (fall[i])
      );
    end
  endgenerate

  always_comb begin
    if (stb.renaWr) renaNext = wd;
    else renaNext = (renaQ | (stb.renaSet ? wd : '0)) & ~(stb.renaClr ? wd : '0);

    if (stb.fenaWr) fenaBase = wd;
    else fenaBase = (fenaQ | (stb.fenaSet ? wd : '0)) & ~(stb.fenaClr ? wd : '0);
    // a status write on a level channel flips its active level
    fenaNext = fenaBase ^ (stb.pendClr ? (wd & modeQ) : '0);

    pendMask  = stb.pendClr ? wd : '0;
    redgeNext = (redgeQ & ~(stb.redgeClr ? wd : '0)) | rise;
    fedgeNext = (fedgeQ & ~(stb.fedgeClr ? wd : '0)) | fall;

    for (int i = 0; i < NUM_CH; i++) begin
      if (modeQ[i]) pendNext[i] = renaQ[i] & (lvl[i] == fenaQ[i]);
      else pendNext[i] = (pendQ[i] & ~pendMask[i]) | (rise[i] & renaQ[i]) | (fall[i] & fenaQ[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      renaQ  <= '0;
      fenaQ  <= '0;
      redgeQ <= '0;
      fedgeQ <= '0;
      pendQ  <= '0;
      selQ   <= '0;
    end else begin
      if (stb.modeWr) modeQ <= wd;
      renaQ  <= renaNext;
      fenaQ  <= fenaNext;
      redgeQ <= redgeNext;
      fedgeQ <= fedgeNext;
      pendQ  <= pendNext;
      for (int i = 0; i < NUM_CH; i++) begin
        if (selWr[i]) selQ[i] <= selData;
      end
    end
  end
endmodule

// File: rtl/pin_irq_unit.sv
`timescale 1ns/1ps
module pin_irq_unit import pin_irq_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int P0_W   = 24,
  parameter int P1_W   = 32,
  parameter int P2_W   = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [P0_W-1:0]   port0Pins,
  input  logic [P1_W-1:0]   port1Pins,
  input  logic [P2_W-1:0]   port2Pins,
  output logic [NUM_CH-1:0] irqOut
);
  localparam int PIN_N  = P0_W + P1_W + P2_W;
  localparam int CODE_W = $clog2(PIN_N);

  pinIrqStb_t               stb;
  logic [NUM_CH-1:0]        selWr;
  logic [NUM_CH-1:0]        modeQ, renaQ, fenaQ, redgeQ, fedgeQ, pendQ;
  logic [NUM_CH*CODE_W-1:0] selFlat;
  logic [PIN_N-1:0]         allPins;

  // linear code order: port 0 first, then port 1, then port 2
  assign allPins = {port2Pins, port1Pins, port0Pins};

  pin_irq_ctrl #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busSel (busSel),  .busWr (busWr),   .busAddr (busAddr),
    .modeQ  (modeQ),   .renaQ (renaQ),   .fenaQ   (fenaQ),
    .redgeQ (redgeQ),  .fedgeQ (fedgeQ), .pendQ   (pendQ),
    .selFlat(selFlat), .stb   (stb),     .selWr   (selWr),
    .busRdata(busRdata)
  );

  pin_irq_dpath #(.NUM_CH(NUM_CH), .PIN_N(PIN_N), .CODE_W(CODE_W), .DATA_W(DATA_W)) u_dpath (
    .clk    (clk),     .rstN   (rstN),   .stb    (stb),
    .selWr  (selWr),   .wrData (busWdata), .allPins(allPins),
    .modeQ  (modeQ),   .renaQ  (renaQ),  .fenaQ  (fenaQ),
    .redgeQ (redgeQ),  .fedgeQ (fedgeQ), .pendQ  (pendQ),
    .selFlat(selFlat)
  );

  assign irqOut = pendQ;
endmodule

// File: rtl/pin_irq_unit_checker.sv
`timescale 1ns/1ps
module pin_irq_unit_checker import pin_irq_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [NUM_CH-1:0] modeQ,
  input logic [NUM_CH-1:0] renaQ,
  input logic [NUM_CH-1:0] fenaQ,
  input logic [NUM_CH-1:0] redgeQ,
  input logic [NUM_CH-1:0] pendQ
);
  logic wrAct;
  int   addrI;
  assign wrAct = busSel && busWr;
  assign addrI = int'(busAddr);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      AST_SET_ALIAS_ARMS: assert property (@(posedge clk) disable iff (!rstN)
        (wrAct && addrI == OFS_RSET && busWdata[i]) |=> renaQ[i]); // R3
      AST_CLR_ALIAS_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
        (wrAct && addrI == OFS_RCLR && busWdata[i]) |=> !renaQ[i]); // R3
      AST_UNARMED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        (!modeQ[i] && !pendQ[i] && !renaQ[i] && !fenaQ[i]) |=> !pendQ[i]); // R6
      AST_REDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (redgeQ[i] && !(wrAct && addrI == OFS_REDGE && busWdata[i])) |=> redgeQ[i]); // R7
      AST_PEND_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
        (wrAct && addrI == OFS_PEND && busWdata[i] && !modeQ[i] && !renaQ[i] && !fenaQ[i])
        |=> !pendQ[i]); // R8
      AST_LEVEL_DISARMED_LOW: assert property (@(posedge clk) disable iff (!rstN)
        (modeQ[i] && !renaQ[i]) |=> !pendQ[i]); // R9
      AST_LEVEL_WRITE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
        (wrAct && addrI == OFS_PEND && busWdata[i] && modeQ[i]) |=> (fenaQ[i] != $past(fenaQ[i]))); // R10
    end
  endgenerate
endmodule

bind pin_irq_unit pin_irq_unit_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .modeQ   (modeQ),
  .renaQ   (renaQ),
  .fenaQ   (fenaQ),
  .redgeQ  (redgeQ),
  .pendQ   (pendQ)
);

// File: tb/pin_irq_unit_bench.sv
`timescale 1ns/1ps
module pin_irq_unit_bench;
  localparam int A_MODE = 0, A_RENA = 1, A_RSET = 2, A_RCLR = 3, A_FENA = 4;
  localparam int A_FSET = 5, A_FCLR = 6, A_REDGE = 7, A_FEDGE = 8, A_PEND = 9, A_SEL = 16;

  // {code, port, pin}
  localparam logic [13:0] MAP_VEC [8] = '{
    {6'd0,  2'd0, 6'd0},  {6'd10, 2'd0, 6'd10}, {6'd23, 2'd0, 6'd23},
    {6'd24, 2'd1, 6'd0},  {6'd40, 2'd1, 6'd16}, {6'd55, 2'd1, 6'd31},
    {6'd56, 2'd2, 6'd0},  {6'd63, 2'd2, 6'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [23:0] p0 = '0;
  logic [31:0] p1 = '0;
  logic [7:0]  p2 = '0;
  logic [7:0]  irqOut;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  pin_irq_unit u_pin_irq_unit (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .port0Pins(p0), .port1Pins(p1),
    .port2Pins(p2), .irqOut(irqOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(int a, logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = 5'(a); busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rdCheck(string tag, int a, logic [31:0] exp);
    busSel = 1'b1; busWr = 1'b0; busAddr = 5'(a);
    #1;
    check(tag, busRdata, exp);
    busSel = 1'b0;
  endtask

  task automatic drivePin(int port, int pin, logic v);
    case (port)
      0: p0[pin] = v;
      1: p1[pin] = v;
      default: p2[pin] = v;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    foreach (MAP_VEC[k]) rdCheck("R1 reset reg", (k < 6) ? k * 2 - (k > 3 ? 1 : 0) : A_SEL + k, 32'h0);
    rdCheck("R1 reset pend", A_PEND, 32'h0);
    rdCheck("R1 reset redge", A_REDGE, 32'h0);
    check("R1 reset irq", 32'(irqOut), 32'h0);

    // R2 table walk: channel 0 rising edge through every port range
    wrReg(A_RENA, 32'h01);
    for (int v = 0; v < 8; v++) begin
      logic [5:0] code;
      logic [1:0] port;
      logic [5:0] pin;
      {code, port, pin} = MAP_VEC[v];
      wrReg(A_SEL, 32'(code));
      rdCheck("R2 select readback", A_SEL, 32'(code));
      tick(4);
      wrReg(A_PEND, 32'hFF);
      check("R2 idle before pin", 32'(irqOut[0]), 32'h0);
      drivePin(int'(port), int'(pin), 1'b1);
      tick(3);
      check($sformatf("R2 code %0d reaches channel", code), 32'(irqOut[0]), 32'h1);
      drivePin(int'(port), int'(pin), 1'b0);
      tick(4);
      wrReg(A_PEND, 32'hFF);
    end

    // R3 aliases, R12 alias and unmapped reads
    wrReg(A_RENA, 32'h0);
    wrReg(A_RSET, 32'h05);  rdCheck("R3 set alias", A_RENA, 32'h05);
    wrReg(A_RSET, 32'h02);  rdCheck("R3 set alias merge", A_RENA, 32'h07);
    wrReg(A_RCLR, 32'h01);  rdCheck("R3 clr alias", A_RENA, 32'h06);
    wrReg(A_RCLR, 32'h00);  rdCheck("R3 zero clr no effect", A_RENA, 32'h06);
    wrReg(A_FSET, 32'hA0);  rdCheck("R3 fall set alias", A_FENA, 32'hA0);
    wrReg(A_FCLR, 32'h80);  rdCheck("R3 fall clr alias", A_FENA, 32'h20);
    rdCheck("R12 alias reads zero", A_RSET, 32'h0);
    rdCheck("R12 alias reads zero", A_FCLR, 32'h0);
    rdCheck("R12 unmapped reads zero", 12, 32'h0);
    wrReg(A_RENA, 32'h0);   rdCheck("R3 direct write", A_RENA, 32'h0);
    wrReg(A_FENA, 32'h0);   rdCheck("R3 direct write fall", A_FENA, 32'h0);

    // channel 1: falling edge only
    wrReg(A_SEL + 1, 32'd1);
    wrReg(A_FSET, 32'h02);
    tick(4);
    wrReg(A_PEND, 32'hFF); wrReg(A_REDGE, 32'hFF); wrReg(A_FEDGE, 32'hFF);
    p0[1] = 1'b1;
    tick(4);
    check("R6 unarmed rise ignored", 32'(irqOut[1]), 32'h0);
    rdCheck("R7 rise recorded though unarmed", A_REDGE, 32'h02);
    p0[1] = 1'b0;
    tick(2);
    check("R4 not before third edge", 32'(irqOut[1]), 32'h0);
    tick(1);
    check("R5 falling edge pends", 32'(irqOut[1]), 32'h1);
    rdCheck("R7 fall recorded", A_FEDGE, 32'h02);
    wrReg(A_REDGE, 32'h02);
    rdCheck("R7 history write-one clear", A_REDGE, 32'h0);
    wrReg(A_PEND, 32'h00);
    check("R8 zero write keeps pend", 32'(irqOut[1]), 32'h1);
    rdCheck("R11 irq mirrors pend", A_PEND, 32'(irqOut));
    wrReg(A_PEND, 32'h02);
    check("R8 write one clears", 32'(irqOut[1]), 32'h0);

    // channel 2: both edges
    wrReg(A_SEL + 2, 32'd2);
    wrReg(A_RSET, 32'h04); wrReg(A_FSET, 32'h04);
    tick(4);
    wrReg(A_PEND, 32'hFF);
    p0[2] = 1'b1;
    tick(2);
    check("R4 rise latency two edges", 32'(irqOut[2]), 32'h0);
    tick(1);
    check("R4 rise at third edge", 32'(irqOut[2]), 32'h1);
    wrReg(A_PEND, 32'h04);
    check("R8 clear both-armed", 32'(irqOut[2]), 32'h0);
    p0[2] = 1'b0;
    tick(3);
    check("R5 both armed fall pends", 32'(irqOut[2]), 32'h1);
    wrReg(A_PEND, 32'h04);

    // channel 3: level mode
    wrReg(A_SEL + 3, 32'd3);
    wrReg(A_MODE, 32'h08);
    rdCheck("R9 mode readback", A_MODE, 32'h08);
    wrReg(A_RSET, 32'h08); wrReg(A_FSET, 32'h08);
    tick(3);
    check("R9 inactive level low", 32'(irqOut[3]), 32'h0);
    p0[3] = 1'b1;
    tick(3);
    check("R9 active high level", 32'(irqOut[3]), 32'h1);
    p0[3] = 1'b0;
    tick(3);
    check("R9 level removed", 32'(irqOut[3]), 32'h0);
    wrReg(A_PEND, 32'h08);
    rdCheck("R10 status write flips level", A_FENA, 32'h06);
    tick(1);
    check("R10 active low now pends", 32'(irqOut[3]), 32'h1);
    wrReg(A_RCLR, 32'h08);
    tick(1);
    check("R9 disarmed level drops", 32'(irqOut[3]), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule